// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for the management register set of a single Ethernet PHY, as seen from a MAC's management port. The MAC first loads a target word that names a PHY address and a register index. Reads then come back combinationally on `rd_data`, and a write strobe stores `wr_data` into the selected register.

The model holds six registers: control, status, two identifier words, the local advertisement and the link-partner ability. An external `link_up` input is sampled every clock. It drives the link bit of the status word and selects between two fixed link-partner ability values.

A write to the control register with its top bit set acts as a PHY soft reset. It restores control and advertisement to their defaults, and the written value is discarded. Only one PHY address answers. Traffic to any other address reads all ones and changes nothing.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After `rst_n` is low on a clock edge, the control register holds 0x3100, the advertisement register holds 0x01E1 and the target word is 0x0000.
- R2: The target word is loaded from `tgt_word` on a clock edge where `tgt_load` is high. The PHY address sits in bits [15:8] and the register index in bits [7:0]. `rd_data` reflects the new target from the cycle after the load.
- R3: While the target address is not 1, `rd_data` reads 0xFFFF and a write strobe changes no register.
- R4: At address 1, index 2 reads 0x0000, index 3 reads 0x8201, and any index above 5 reads 0x0000.
- R5: Index 1 (status) reads 0x7848 with bit 2 set when the sampled link is up and clear when it is down.
- R6: Index 5 (link partner) reads 0x01E1 when the sampled link is up and 0x0080 when it is down.
- R7: `link_up` is captured on the clock edge. A change shows on `rd_data` only from the next cycle, never in the same cycle.
- R8: A write to index 0 with data bit 15 set restores control to 0x3100 and advertisement to 0x01E1, and the written value is not stored.
- R9: A write to index 0 with bit 15 clear stores the data as written. A write to index 4 (advertisement) stores the data as written.
- R10: Writes to indices 1, 2, 3, 5 and to any index above 5 leave every readable value unchanged.
- R11: A write strobe acts on the target that was held before the edge, even when `tgt_load` loads a new target on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tgt_load | input | 1 | Load the target word from `tgt_word` |
| tgt_word | input | 16 | PHY address [15:8] and register index [7:0] |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Data to write |
| link_up | input | 1 | Link state from the line side, sampled each clock |
| rd_data | output | 16 | Value of the selected register |

## Verification
The assertions assume that `tgt_load` and `wr_en` are never high in the same cycle when they predict a value from a write, so the target they track is the one the write acts on. They also assume that `link_up` is a clean, synchronous level. The stimulus drives all inputs just after the falling edge. It only overlaps a target load with a write in the one directed case for R11, and there the write-related properties are written to exclude a concurrent load. Link changes are applied as single steps between register accesses.

// File: rtl/phy_mgmt_pkg.sv
// Package: shared constants for the PHY management register model.
// Assumes 16-bit management data words.
package phy_mgmt_pkg;
    localparam int unsigned DATA_W       = 16;
    localparam int unsigned REG_CONTROL  = 0;
    localparam int unsigned REG_STATUS   = 1;
    localparam int unsigned REG_IDHI     = 2;
    localparam int unsigned REG_IDLO     = 3;
    localparam int unsigned REG_ADVERT   = 4;
    localparam int unsigned REG_PARTNER  = 5;
    localparam int unsigned SOFTRST_BIT  = 15;
    localparam int unsigned LINK_BIT     = 2;
    localparam logic [DATA_W-1:0] CONTROL_DEF = 16'h3100;
    localparam logic [DATA_W-1:0] STATUS_BASE = 16'h7848;
    localparam logic [DATA_W-1:0] ADVERT_DEF  = 16'h01E1;
    localparam logic [DATA_W-1:0] PARTNER_UP  = 16'h01E1;
    localparam logic [DATA_W-1:0] PARTNER_DN  = 16'h0080;
    localparam logic [DATA_W-1:0] ID_HI_VAL   = 16'h0000;
    localparam logic [DATA_W-1:0] ID_LO_VAL   = 16'h8201;
    localparam logic [DATA_W-1:0] ABSENT_VAL  = 16'hFFFF;
endpackage

// File: rtl/phy_target_reg.sv
// Module: holds the management target (PHY address, register index) and
// reports whether the address matches this PHY. Assumes synchronous reset.
module phy_target_reg #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned PHY_ADDR = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W+IDX_W-1:0] word,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;

    // Capture the target word on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            addr_q <= word[ADDR_W+IDX_W-1:IDX_W];
            idx_q  <= word[IDX_W-1:0];
        end
    end

    // Address match against the one PHY address this model answers at.
    always_comb begin
        hit = (addr_q == ADDR_W'(PHY_ADDR));
        idx = idx_q;
    end
endmodule

// File: rtl/phy_ctrl_bank.sv
// Module: the writable control and advertisement registers, including the
// soft reset carried by the control register's top bit.
// Assumes wr_en is already qualified by an address match.
module phy_ctrl_bank
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] control,
    output logic [DATA_W-1:0] advert
);
    logic to_control;
    logic to_advert;
    logic soft_rst;

    // Decode which writable register a strobe targets.
    always_comb begin
        to_control = wr_en && (idx == IDX_W'(REG_CONTROL));
        to_advert  = wr_en && (idx == IDX_W'(REG_ADVERT));
        soft_rst   = to_control && wr_data[SOFTRST_BIT];
    end

    // Register update: reset defaults, soft reset, or store as written.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            control <= CONTROL_DEF;
            advert  <= ADVERT_DEF;
        end else begin
            if (to_control) control <= wr_data;
            if (to_advert)  advert  <= wr_data;
        end
    end
endmodule

// File: rtl/phy_link_track.sv
// Module: samples the external link level and derives the status word and
// link-partner ability word from it. Assumes link_in is synchronous.
module phy_link_track
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_in,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] partner
);
    logic link_q;

    // Sample the link level once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= 1'b0;
        else        link_q <= link_in;
    end

    // Build status and partner words from the sampled link.
    always_comb begin
        status           = STATUS_BASE;
        status[LINK_BIT] = link_q;
        partner          = link_q ? PARTNER_UP : PARTNER_DN;
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
// Module: top of the PHY management register model. Ties the target
// register, writable bank and link tracker together and selects read data.
// Assumes a single PHY at address PHY_ADDR; read data is combinational.
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned PHY_ADDR = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tgt_load,
    input  logic [ADDR_W+IDX_W-1:0] tgt_word,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    link_up,
    output logic [DATA_W-1:0]       rd_data
);
    logic              sel_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic              bank_we;
    logic [DATA_W-1:0] control;
    logic [DATA_W-1:0] advert;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] partner;

    phy_target_reg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PHY_ADDR(PHY_ADDR)) u_tgt (
        .clk(clk), .rst_n(rst_n), .load(tgt_load), .word(tgt_word),
        .hit(sel_hit), .idx(sel_idx)
    );

    // Writes only reach the bank when the held target names this PHY.
    always_comb bank_we = wr_en && sel_hit;

    phy_ctrl_bank #(.IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bank_we), .idx(sel_idx),
        .wr_data(wr_data), .control(control), .advert(advert)
    );

    phy_link_track u_link (
        .clk(clk), .rst_n(rst_n), .link_in(link_up),
        .status(status), .partner(partner)
    );

    // Read multiplexer over the selected register.
    always_comb begin
        if (!sel_hit) begin
            rd_data = ABSENT_VAL;
        end else begin
            unique case (sel_idx)
                IDX_W'(REG_CONTROL): rd_data = control;
                IDX_W'(REG_STATUS):  rd_data = status;
                IDX_W'(REG_IDHI):    rd_data = ID_HI_VAL;
                IDX_W'(REG_IDLO):    rd_data = ID_LO_VAL;
                IDX_W'(REG_ADVERT):  rd_data = advert;
                IDX_W'(REG_PARTNER): rd_data = partner;
                default:             rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/phy_mgmt_checker.sv
// Module: property checker for phy_mgmt_regs, attached by bind.
// Tracks the target word seen at the ports and checks read results.
module phy_mgmt_checker #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned PHY_ADDR = 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tgt_load,
    input logic [ADDR_W+IDX_W-1:0] tgt_word,
    input logic                    wr_en,
    input logic [15:0]             wr_data,
    input logic                    link_up,
    input logic [15:0]             rd_data
);
    localparam logic [ADDR_W+IDX_W-1:0] W_CTRL   = {ADDR_W'(PHY_ADDR), IDX_W'(0)};
    localparam logic [ADDR_W+IDX_W-1:0] W_STAT   = {ADDR_W'(PHY_ADDR), IDX_W'(1)};
    localparam logic [ADDR_W+IDX_W-1:0] W_IDLO   = {ADDR_W'(PHY_ADDR), IDX_W'(3)};
    localparam logic [ADDR_W+IDX_W-1:0] W_PART   = {ADDR_W'(PHY_ADDR), IDX_W'(5)};

    logic [ADDR_W+IDX_W-1:0] seen_tgt;

    // Shadow of the target as loaded through the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_tgt <= '0;
        else if (tgt_load) seen_tgt <= tgt_word;
    end

    a_r3_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_load && tgt_word[ADDR_W+IDX_W-1:IDX_W] != ADDR_W'(PHY_ADDR))
        |=> rd_data == 16'hFFFF);

    a_r4_id_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_load && tgt_word == W_IDLO) |=> rd_data == 16'h8201);

    a_r5_status_link: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_load && tgt_word == W_STAT)
        |=> rd_data == (16'h7848 | {13'b0, $past(link_up), 2'b00}));

    a_r6_partner_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_load && tgt_word == W_PART && link_up) |=> rd_data == 16'h01E1);

    a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15] && !tgt_load && seen_tgt == W_CTRL)
        |=> rd_data == 16'h3100);

    a_r9_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[15] && !tgt_load && seen_tgt == W_CTRL)
        |=> rd_data == $past(wr_data));
endmodule

bind phy_mgmt_regs phy_mgmt_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PHY_ADDR(PHY_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .tgt_load(tgt_load), .tgt_word(tgt_word),
    .wr_en(wr_en), .wr_data(wr_data), .link_up(link_up), .rd_data(rd_data)
);

// File: tb/sim_phy_mgmt_regs.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks per requirement.
module sim_phy_mgmt_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_load = 1'b0;
    logic [15:0] tgt_word = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        link_up = 1'b0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [15:0] m_tgt, m_ctrl, m_adv;
    logic        m_link;

    always #5 clk = ~clk;

    phy_mgmt_regs u0 (
        .clk(clk), .rst_n(rst_n), .tgt_load(tgt_load), .tgt_word(tgt_word),
        .wr_en(wr_en), .wr_data(wr_data), .link_up(link_up), .rd_data(rd_data)
    );

    function automatic logic [15:0] model_read();
        if (m_tgt[15:8] != 8'd1) return 16'hFFFF;
        case (m_tgt[7:0])
            8'd0: return m_ctrl;
            8'd1: return m_link ? 16'h784C : 16'h7848;
            8'd2: return 16'h0000;
            8'd3: return 16'h8201;
            8'd4: return m_adv;
            8'd5: return m_link ? 16'h01E1 : 16'h0080;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tgt = 16'h0000; m_ctrl = 16'h3100; m_adv = 16'h01E1; m_link = 1'b0;
        end else begin
            if (wr_en && m_tgt[15:8] == 8'd1) begin
                if (m_tgt[7:0] == 8'd0) begin
                    if (wr_data[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
                    else m_ctrl = wr_data;
                end else if (m_tgt[7:0] == 8'd4) begin
                    m_adv = wr_data;
                end
            end
            if (tgt_load) m_tgt = tgt_word;
            m_link = link_up;
        end
    end

    // Model comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rd_data !== model_read()) begin
                errors++;
                $display("FAIL R2 model compare: actual=%h expected=%h", rd_data, model_read());
            end
        end
    end

    task automatic chk(input logic [15:0] exp, input string tag);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, rd_data, exp);
        end
    endtask

    task automatic step(input logic ld, input logic [15:0] w, input logic we, input logic [15:0] d);
        tgt_load = ld; tgt_word = w; wr_en = we; wr_data = d;
        @(negedge clk);
        tgt_load = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] w);
        step(1'b1, w, 1'b0, 16'h0);
    endtask

    task automatic wr(input logic [15:0] d);
        step(1'b0, 16'h0, 1'b1, d);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(16'hFFFF, "R1 reset target reads absent");
        rst_n = 1'b1;
        @(negedge clk);
        chk(16'hFFFF, "R1 target zero after reset");
        rd(16'h0100); chk(16'h3100, "R1 control default");
        rd(16'h0104); chk(16'h01E1, "R1 advert default");
        rd(16'h0102); chk(16'h0000, "R4 id high");
        rd(16'h0103); chk(16'h8201, "R4 id low");
        rd(16'h0107); chk(16'h0000, "R4 unknown index 7");
        rd(16'h01FF); chk(16'h0000, "R4 unknown index 255");
        rd(16'h0101); chk(16'h7848, "R5 status link down");
        // R7: raising link shows only after the edge
        link_up = 1'b1;
        chk(16'h7848, "R7 no same-cycle link effect");
        step(1'b0, 16'h0, 1'b0, 16'h0);
        chk(16'h784C, "R7 link visible next cycle");
        chk(16'h784C, "R5 status link up");
        rd(16'h0105); chk(16'h01E1, "R6 partner link up");
        link_up = 1'b0;
        step(1'b0, 16'h0, 1'b0, 16'h0);
        chk(16'h0080, "R6 partner link down");
        // R9 stores
        rd(16'h0100); wr(16'h2100); chk(16'h2100, "R9 control stored");
        rd(16'h0104); wr(16'h0061); chk(16'h0061, "R9 advert stored");
        // R8 soft reset
        rd(16'h0100); wr(16'h8000); chk(16'h3100, "R8 control restored");
        rd(16'h0104); chk(16'h01E1, "R8 advert restored");
        // R10 read-only and unknown indices
        rd(16'h0101); wr(16'hFFFF); chk(16'h7848, "R10 status write ignored");
        rd(16'h0103); wr(16'h0000); chk(16'h8201, "R10 id write ignored");
        rd(16'h0105); wr(16'hFFFF); chk(16'h0080, "R10 partner write ignored");
        rd(16'h0109); wr(16'h1234);
        rd(16'h0100); chk(16'h3100, "R10 unknown write leaves control");
        rd(16'h0104); chk(16'h01E1, "R10 unknown write leaves advert");
        // R3 foreign address
        rd(16'h0200); chk(16'hFFFF, "R3 foreign address read");
        wr(16'h0042);
        rd(16'h0000); wr(16'h0011);
        rd(16'h0100); chk(16'h3100, "R3 foreign write ignored");
        // R11 write uses the previous target on a simultaneous load
        step(1'b1, 16'h0104, 1'b1, 16'h0021);
        chk(16'h01E1, "R11 advert untouched");
        rd(16'h0100); chk(16'h0021, "R11 write hit old target");
        link_up = 1'b1;
        rd(16'h0101); chk(16'h784C, "R5 status link up again");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule